// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Engine

This block runs one DMA channel from a chain of 16-byte command descriptors held in memory. After a start pulse, it reads the descriptor at the given address through a word-wide memory master port. It then acts on the 4-bit opcode. Data commands move words between memory and a device-side stream: output commands read memory and send stream beats, and input commands accept stream beats and write them to memory. Quad commands move a single word between memory and an internal holding register. NOP does nothing, and STOP halts the channel.

Each descriptor carries three 2-bit policies, for interrupt, branch and wait. Each policy is tested against a condition built from the channel's device status bits and a mask and match pair for that policy. When a data or quad command completes, the engine writes the residual byte count and a status halfword back into the descriptor. It then moves to the next descriptor, or to the branch address when the branch policy fires, and may raise a one-cycle interrupt.

Top module: `dma_cmd_engine`

## Requirements
- R1: After a synchronous active-low reset, `active`, `irq`, `mem_req`, `out_valid` and `in_ready` are all 0.
- R2: A `start` pulse while idle sets `active` and reads descriptor words 0, 1 and 2 at byte offsets +0, +4 and +8. Word 0 holds the request count in [15:0] and the command in [31:16]. Within the command, [15:12] is the opcode, [5:4] the interrupt policy, [3:2] the branch policy and [1:0] the wait policy. Word 1 is the data address and word 2 is the branch address. The memory request, address and write flag stay stable until `mem_ready`.
- R3: Opcodes 0 (output, more follows) and 1 (output, last) read ceil(count/4) words, rising from the data address, and send each one as a stream beat that holds stable until `out_ready`. `out_last` is 1 only on the final beat of opcode 1.
- R4: Opcodes 2 and 3 (input) accept beats and write them to rising word addresses. Input stops when the count runs out or after a beat that carries `in_last`. Each beat uses up min(4, remaining) bytes.
- R5: Opcodes 0 to 5 end with one write of {status, residual} to descriptor offset +12. Status is 0x0400 OR'd with `dev_status`. Residual is the count of unused bytes, and it is 0 for quad commands. NOP (6) and undefined opcodes do no write-back.
- R6: A policy code of 0 never fires, 1 fires when the condition holds, 2 fires when it does not hold, and 3 always fires. The condition is (`dev_status` & mask) == match.
- R7: When the branch policy fires, the next descriptor is the branch address. Otherwise it is the current descriptor address plus 16.
- R8: When the interrupt policy fires at completion, `irq` pulses high for exactly one cycle. It stays low otherwise.
- R9: While the wait policy fires, the engine holds before write-back and advance. It resumes once the policy no longer fires.
- R10: STOP (7) clears `active`, does no write-back and fetches nothing more.
- R11: Load-quad (5) copies the word at the data address into an internal register. Store-quad (4) writes that register to the data address.
- R12: A request count above 0x8000 is treated as 0x8000. A count of 0 moves no data and writes back a residual of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin the chain at `start_addr` when idle |
| start_addr | input | 32 | Byte address of the first descriptor |
| dev_status | input | 8 | Device status bits used by the conditions |
| int_mask | input | 8 | Interrupt condition mask |
| int_match | input | 8 | Interrupt condition match value |
| br_mask | input | 8 | Branch condition mask |
| br_match | input | 8 | Branch condition match value |
| wt_mask | input | 8 | Wait condition mask |
| wt_match | input | 8 | Wait condition match value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when 1, read when 0 |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Completes the access in this cycle |
| out_valid | output | 1 | Output stream beat valid |
| out_data | output | 32 | Output stream data |
| out_last | output | 1 | Final beat of an output-last command |
| out_ready | input | 1 | Device accepts the output beat |
| in_valid | input | 1 | Input stream beat valid |
| in_data | input | 32 | Input stream data |
| in_last | input | 1 | Device ends the input packet with this beat |
| in_ready | output | 1 | Engine accepts an input beat |
| active | output | 1 | Channel is running a chain |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest condition to reach is the wait stall. The engine must have finished its data beats and then be held by a live status condition, and from outside this shows only as a write-back that has not happened yet. The bench sets a status bit that the wait policy matches, starts a one-beat output descriptor, and after many idle cycles checks that the descriptor's status word still holds its sentinel value. It then clears the bit and checks that the write-back arrives. Branch decisions are made visible with trap descriptors placed on the path not taken: each trap is an output command, so the scoreboard would see an unexpected beat if the engine went there. A count above the limit drives a full 8192-beat transfer under uneven ready patterns.

// File: rtl/dma_cmd_pkg.sv
// Shared opcode, policy and state definitions for the DMA command engine.
// Assumes the 32-bit little-endian descriptor word layout used by the engine.
package dma_cmd_pkg;

    localparam logic [3:0] OP_OUT_MORE  = 4'd0;
    localparam logic [3:0] OP_OUT_LAST  = 4'd1;
    localparam logic [3:0] OP_IN_MORE   = 4'd2;
    localparam logic [3:0] OP_IN_LAST   = 4'd3;
    localparam logic [3:0] OP_STORE_Q   = 4'd4;
    localparam logic [3:0] OP_LOAD_Q    = 4'd5;
    localparam logic [3:0] OP_NOP       = 4'd6;
    localparam logic [3:0] OP_STOP      = 4'd7;

    localparam logic [1:0] POL_NEVER    = 2'd0;
    localparam logic [1:0] POL_IF_TRUE  = 2'd1;
    localparam logic [1:0] POL_IF_FALSE = 2'd2;
    localparam logic [1:0] POL_ALWAYS   = 2'd3;

    localparam int POL_INT = 0;
    localparam int POL_BR  = 1;
    localparam int POL_WT  = 2;
    localparam int NUM_POL = 3;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH, S_DECODE, S_OUT_RD, S_OUT_TX, S_IN_RX, S_IN_WR,
        S_QLOAD, S_QSTORE, S_WAITC, S_WB, S_ADV
    } eng_state_e;

    // True for opcodes that end with a descriptor write-back.
    function automatic logic op_writes_back(input logic [3:0] op);
        return op <= OP_LOAD_Q;
    endfunction

    // True for the two quad opcodes.
    function automatic logic op_is_quad(input logic [3:0] op);
        return (op == OP_STORE_Q) || (op == OP_LOAD_Q);
    endfunction

endpackage

// File: rtl/dma_policy_eval.sv
// Evaluates one 2-bit descriptor policy against the masked device status.
// Pure combinational; assumes the caller samples the result when it needs it.
module dma_policy_eval #(
    parameter int SW = 8
) (
    input  logic [1:0]    code,
    input  logic [SW-1:0] status,
    input  logic [SW-1:0] mask,
    input  logic [SW-1:0] match,
    output logic          fire
);
    import dma_cmd_pkg::*;

    logic cond;

    // Condition holds when the masked status equals the match value.
    always_comb begin
        cond = ((status & mask) == match);
        unique case (code)
            POL_NEVER:    fire = 1'b0;
            POL_IF_TRUE:  fire = cond;
            POL_IF_FALSE: fire = ~cond;
            default:      fire = 1'b1;
        endcase
    end
endmodule

// File: rtl/dma_byte_counter.sv
// Tracks the bytes left in a data command. Loads the request count clamped
// to MAX_CNT and subtracts up to STEP bytes per beat. Assumes load and step
// never coincide.
module dma_byte_counter #(
    parameter int              CNT_W   = 16,
    parameter logic [CNT_W-1:0] MAX_CNT = 16'h8000,
    parameter int              STEP    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic [CNT_W-1:0] left,
    output logic             final_beat,
    output logic             empty
);
    localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

    // Clamp on load, saturate at zero on each beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left <= '0;
        end else if (load) begin
            left <= (load_val > MAX_CNT) ? MAX_CNT : load_val;
        end else if (step) begin
            left <= (left > STEP_V) ? (left - STEP_V) : '0;
        end
    end

    // The beat that leaves nothing behind is the final one.
    always_comb begin
        empty      = (left == '0);
        final_beat = !empty && (left <= STEP_V);
    end
endmodule

// File: rtl/dma_cmd_engine.sv
// Single-channel descriptor-driven DMA engine. Fetches descriptors over a
// word-wide memory port (one access per mem_req & mem_ready cycle, read data
// valid in that cycle), runs stream or quad transfers, evaluates interrupt,
// branch and wait policies, writes back residual and status, then advances.
// Assumes word-aligned descriptor and data addresses.
module dma_cmd_engine #(
    parameter int               AW      = 32,
    parameter int               SW      = 8,
    parameter int               CNT_W   = 16,
    parameter logic [CNT_W-1:0] MAX_CNT = 16'h8000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [SW-1:0] dev_status,
    input  logic [SW-1:0] int_mask,
    input  logic [SW-1:0] int_match,
    input  logic [SW-1:0] br_mask,
    input  logic [SW-1:0] br_match,
    input  logic [SW-1:0] wt_mask,
    input  logic [SW-1:0] wt_match,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ready,
    output logic          out_valid,
    output logic [31:0]   out_data,
    output logic          out_last,
    input  logic          out_ready,
    input  logic          in_valid,
    input  logic [31:0]   in_data,
    input  logic          in_last,
    output logic          in_ready,
    output logic          active,
    output logic          irq
);
    import dma_cmd_pkg::*;

    localparam int               DW        = 32;
    localparam int               BYTES     = DW / 8;
    localparam int               STAT_W    = 16;
    localparam int               DESC_WRDS = 3;
    localparam logic [AW-1:0]    DESC_SIZE = AW'(16);
    localparam logic [AW-1:0]    WB_OFS    = AW'(12);
    localparam logic [AW-1:0]    BEAT_INC  = AW'(BYTES);
    localparam logic [STAT_W-1:0] ACT_BIT  = 16'h0400;

    eng_state_e        state;
    logic [AW-1:0]     desc_ptr, data_ptr, br_addr;
    logic [1:0]        word_idx;
    logic [3:0]        opcode;
    logic [1:0]        int_pol, br_pol, wt_pol;
    logic [CNT_W-1:0]  req_cnt;
    logic [DW-1:0]     xfer_buf, quad_reg;
    logic              in_last_seen;

    logic              cnt_load, cnt_step, cnt_final, cnt_empty;
    logic [CNT_W-1:0]  cnt_left;
    logic [STAT_W-1:0] status_word;
    logic [STAT_W-1:0] resid_word;

    logic [NUM_POL-1:0][1:0]    pol_code;
    logic [NUM_POL-1:0][SW-1:0] pol_mask, pol_match;
    logic [NUM_POL-1:0]         pol_fire;

    // Group the three policies so one evaluator instance serves each.
    always_comb begin
        pol_code[POL_INT]  = int_pol;
        pol_code[POL_BR]   = br_pol;
        pol_code[POL_WT]   = wt_pol;
        pol_mask[POL_INT]  = int_mask;
        pol_mask[POL_BR]   = br_mask;
        pol_mask[POL_WT]   = wt_mask;
        pol_match[POL_INT] = int_match;
        pol_match[POL_BR]  = br_match;
        pol_match[POL_WT]  = wt_match;
    end

    for (genvar g = 0; g < NUM_POL; g++) begin : g_pol
        dma_policy_eval #(.SW(SW)) u_eval (
            .code   (pol_code[g]),
            .status (dev_status),
            .mask   (pol_mask[g]),
            .match  (pol_match[g]),
            .fire   (pol_fire[g])
        );
    end

    dma_byte_counter #(.CNT_W(CNT_W), .MAX_CNT(MAX_CNT), .STEP(BYTES)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cnt_load),
        .load_val   (req_cnt),
        .step       (cnt_step),
        .left       (cnt_left),
        .final_beat (cnt_final),
        .empty      (cnt_empty)
    );

    // Counter controls: load after the last descriptor word, step per beat.
    always_comb begin
        cnt_load = (state == S_FETCH) && mem_ready &&
                   (word_idx == 2'(DESC_WRDS - 1));
        cnt_step = ((state == S_OUT_TX) && out_ready) ||
                   ((state == S_IN_WR) && mem_ready);
    end

    // Write-back fields: live status with the active flag, residual bytes.
    always_comb begin
        status_word = ACT_BIT | STAT_W'(dev_status);
        resid_word  = op_is_quad(opcode) ? '0 : STAT_W'(cnt_left);
    end

    // Port drive decoded from the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        out_valid = 1'b0;
        in_ready  = 1'b0;
        unique case (state)
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = desc_ptr + AW'({word_idx, 2'b00});
            end
            S_OUT_RD, S_QLOAD: begin
                mem_req  = 1'b1;
                mem_addr = data_ptr;
            end
            S_OUT_TX: out_valid = 1'b1;
            S_IN_RX:  in_ready  = 1'b1;
            S_IN_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = data_ptr;
                mem_wdata = xfer_buf;
            end
            S_QSTORE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = data_ptr;
                mem_wdata = quad_reg;
            end
            S_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_ptr + WB_OFS;
                mem_wdata = {status_word, resid_word};
            end
            default: ;
        endcase
        out_data = xfer_buf;
        out_last = (state == S_OUT_TX) && (opcode == OP_OUT_LAST) && cnt_final;
    end

    // Main sequencer: fetch, dispatch, transfer, wait, write back, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= S_IDLE;
            desc_ptr     <= '0;
            data_ptr     <= '0;
            br_addr      <= '0;
            word_idx     <= '0;
            opcode       <= '0;
            int_pol      <= '0;
            br_pol       <= '0;
            wt_pol       <= '0;
            req_cnt      <= '0;
            xfer_buf     <= '0;
            quad_reg     <= '0;
            in_last_seen <= 1'b0;
            active       <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        desc_ptr <= start_addr;
                        word_idx <= '0;
                        active   <= 1'b1;
                        state    <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (mem_ready) begin
                        unique case (word_idx)
                            2'd0: begin
                                opcode  <= mem_rdata[31:28];
                                int_pol <= mem_rdata[21:20];
                                br_pol  <= mem_rdata[19:18];
                                wt_pol  <= mem_rdata[17:16];
                                req_cnt <= mem_rdata[CNT_W-1:0];
                            end
                            2'd1:    data_ptr <= mem_rdata[AW-1:0];
                            default: br_addr  <= mem_rdata[AW-1:0];
                        endcase
                        if (word_idx == 2'(DESC_WRDS - 1)) begin
                            word_idx <= '0;
                            state    <= S_DECODE;
                        end else begin
                            word_idx <= word_idx + 2'd1;
                        end
                    end
                end
                S_DECODE: begin
                    in_last_seen <= 1'b0;
                    unique case (opcode)
                        OP_OUT_MORE, OP_OUT_LAST:
                            state <= cnt_empty ? S_WAITC : S_OUT_RD;
                        OP_IN_MORE, OP_IN_LAST:
                            state <= cnt_empty ? S_WAITC : S_IN_RX;
                        OP_STORE_Q: state <= S_QSTORE;
                        OP_LOAD_Q:  state <= S_QLOAD;
                        OP_STOP: begin
                            active <= 1'b0;
                            state  <= S_IDLE;
                        end
                        default:    state <= S_WAITC;
                    endcase
                end
                S_OUT_RD: begin
                    if (mem_ready) begin
                        xfer_buf <= mem_rdata;
                        state    <= S_OUT_TX;
                    end
                end
                S_OUT_TX: begin
                    if (out_ready) begin
                        data_ptr <= data_ptr + BEAT_INC;
                        state    <= cnt_final ? S_WAITC : S_OUT_RD;
                    end
                end
                S_IN_RX: begin
                    if (in_valid) begin
                        xfer_buf     <= in_data;
                        in_last_seen <= in_last;
                        state        <= S_IN_WR;
                    end
                end
                S_IN_WR: begin
                    if (mem_ready) begin
                        data_ptr <= data_ptr + BEAT_INC;
                        state    <= (cnt_final || in_last_seen) ? S_WAITC : S_IN_RX;
                    end
                end
                S_QLOAD: begin
                    if (mem_ready) begin
                        quad_reg <= mem_rdata;
                        state    <= S_WAITC;
                    end
                end
                S_QSTORE: begin
                    if (mem_ready) state <= S_WAITC;
                end
                S_WAITC: begin
                    if (!pol_fire[POL_WT]) begin
                        state <= op_writes_back(opcode) ? S_WB : S_ADV;
                    end
                end
                S_WB: begin
                    if (mem_ready) state <= S_ADV;
                end
                S_ADV: begin
                    desc_ptr <= pol_fire[POL_BR] ? br_addr : (desc_ptr + DESC_SIZE);
                    word_idx <= '0;
                    state    <= S_FETCH;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Interrupt pulse for the descriptor completing in S_ADV.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (state == S_ADV) && pol_fire[POL_INT];
    end

endmodule

// File: rtl/dma_cmd_engine_chk.sv
// Protocol checker for dma_cmd_engine, attached by bind. Observes ports only.
module dma_cmd_engine_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ready,
    input logic          out_valid,
    input logic [31:0]   out_data,
    input logic          out_last,
    input logic          out_ready,
    input logic          in_ready,
    input logic          active,
    input logic          irq
);
    assert_we_with_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    assert_mem_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_last_in_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> active);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!mem_req && !out_valid && !in_ready));
endmodule

bind dma_cmd_engine dma_cmd_engine_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .active    (active),
    .irq       (irq)
);

// File: tb/tb_dma_cmd_engine.sv
module tb_dma_cmd_engine;
    localparam logic [31:0] SENT = 32'hDEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic [7:0]  dev_status = '0;
    logic [7:0]  int_mask = '0, int_match = '0, br_mask = '0, br_match = '0;
    logic [7:0]  wt_mask = '0, wt_match = '0;
    logic        mem_req, mem_we, mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        out_valid, out_last, out_ready = 1'b0;
    logic [31:0] out_data;
    logic        in_valid = 1'b0, in_last = 1'b0, in_ready;
    logic [31:0] in_data = '0;
    logic        active, irq;

    logic [31:0] mem [0:1023];
    logic [32:0] exp_q [$];
    logic [32:0] in_q [$];
    int checks = 0, fails = 0, irq_cnt = 0, beats = 0, cyc = 0;

    always #5 clk = ~clk;

    dma_cmd_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .dev_status(dev_status), .int_mask(int_mask), .int_match(int_match),
        .br_mask(br_mask), .br_match(br_match), .wt_mask(wt_mask), .wt_match(wt_match),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .active(active), .irq(irq)
    );

    // Memory model: combinational read, write on the accepting edge.
    assign mem_rdata = mem[mem_addr[11:2]];
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_we && mem_ready) mem[mem_addr[11:2]] <= mem_wdata;
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog got=%0d exp=<190000", cyc);
            summary();
        end
    end

    // Driver side of the stream and ready patterns; monitor pops the scoreboard.
    always @(negedge clk) begin
        mem_ready = (cyc % 4) != 3;
        out_ready = (cyc % 5) != 2;
        in_valid  = in_q.size() != 0;
        if (in_valid) {in_last, in_data} = in_q[0];
        #1;
        if (out_valid && out_ready) begin
            beats++;
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R3 got=unexpected beat %h exp=none", out_data);
            end else begin
                check("R3 beat", {out_last, out_data} >> 0 == exp_q[0] ? 32'd1 : {31'd0, out_last} ^ 32'd2, 32'd1);
                void'(exp_q.pop_front());
            end
        end
        if (in_valid && in_ready) void'(in_q.pop_front());
        if (irq) irq_cnt++;
    end

    function automatic logic [31:0] w0(input logic [3:0] op, input logic [1:0] ip,
                                       input logic [1:0] bp, input logic [1:0] wp,
                                       input logic [15:0] cnt);
        return {op, 4'h6, 2'b00, ip, bp, wp, cnt};
    endfunction

    task automatic put_desc(input logic [31:0] a, input logic [3:0] op, input logic [1:0] ip,
                            input logic [1:0] bp, input logic [1:0] wp, input logic [15:0] cnt,
                            input logic [31:0] daddr, input logic [31:0] baddr);
        mem[a[11:2]]     = w0(op, ip, bp, wp, cnt);
        mem[a[11:2] + 1] = daddr;
        mem[a[11:2] + 2] = baddr;
        mem[a[11:2] + 3] = SENT;
    endtask

    // Expected output beats for one output command.
    task automatic push_out(input logic [31:0] base, input int cnt, input logic is_last);
        int n = (cnt + 3) / 4;
        for (int i = 0; i < n; i++)
            exp_q.push_back({is_last && (i == n - 1), mem[(base[11:2] + i) % 1024]});
    endtask

    task automatic kick(input logic [31:0] a);
        @(negedge clk);
        start = 1'b1; start_addr = a;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (active && n < 60000) begin @(negedge clk); n++; end
        check(req, {31'd0, active}, 32'd0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int irq0, beats0;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h1000_0000 + i;
        repeat (3) @(negedge clk);
        check("R1 active", {31'd0, active}, 0);
        check("R1 irq", {31'd0, irq}, 0);
        check("R1 mem_req", {31'd0, mem_req}, 0);
        check("R1 out_valid/in_ready", {30'd0, out_valid, in_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R5 R7: output-more then output-last, falling through to STOP.
        put_desc(32'h100, 4'd0, 2'd0, 2'd0, 2'd0, 16'd8, 32'h400, 32'h0);
        put_desc(32'h110, 4'd1, 2'd0, 2'd0, 2'd0, 16'd6, 32'h410, 32'h0);
        put_desc(32'h120, 4'd7, 2'd0, 2'd0, 2'd0, 16'd0, 32'h0, 32'h0);
        push_out(32'h400, 8, 1'b0);
        push_out(32'h410, 6, 1'b1);
        irq0 = irq_cnt;
        kick(32'h100);
        wait_idle("R10 chain ends");
        check("R3 all beats seen", exp_q.size(), 0);
        check("R5 wb first", mem[32'h10C >> 2], 32'h0400_0000);
        check("R5 wb second", mem[32'h11C >> 2], 32'h0400_0000);
        check("R10 stop no wb", mem[32'h12C >> 2], SENT);
        check("R8 no irq with policy 0", irq_cnt - irq0, 0);

        // R4 R8 R7: input-last ended early by device, irq always, branch always.
        put_desc(32'h140, 4'd3, 2'd3, 2'd3, 2'd0, 16'd12, 32'h500, 32'h180);
        put_desc(32'h150, 4'd0, 2'd0, 2'd0, 2'd0, 16'd4, 32'h400, 32'h0);
        put_desc(32'h180, 4'd7, 2'd0, 2'd0, 2'd0, 16'd0, 32'h0, 32'h0);
        in_q.push_back({1'b0, 32'hA5A5_0001});
        in_q.push_back({1'b1, 32'hA5A5_0002});
        irq0 = irq_cnt;
        kick(32'h140);
        wait_idle("R10 input chain ends");
        check("R4 word0", mem[32'h500 >> 2], 32'hA5A5_0001);
        check("R4 word1", mem[32'h504 >> 2], 32'hA5A5_0002);
        check("R4 word2 untouched", mem[32'h508 >> 2], 32'h1000_0000 + (32'h508 >> 2));
        check("R5 residual 4", mem[32'h14C >> 2], 32'h0400_0004);
        check("R8 one irq", irq_cnt - irq0, 1);

        // R4: input-more runs to exhaustion, residual 0.
        put_desc(32'h1C0, 4'd2, 2'd0, 2'd0, 2'd0, 16'd8, 32'h520, 32'h0);
        put_desc(32'h1D0, 4'd7, 2'd0, 2'd0, 2'd0, 16'd0, 32'h0, 32'h0);
        in_q.push_back({1'b0, 32'h5A5A_0003});
        in_q.push_back({1'b0, 32'h5A5A_0004});
        kick(32'h1C0);
        wait_idle("R4 input-more ends");
        check("R4 full word1", mem[32'h524 >> 2], 32'h5A5A_0004);
        check("R5 residual 0", mem[32'h1CC >> 2], 32'h0400_0000);

        // R6 R7: branch policies; trap at 0x210 would emit an unexpected beat.
        dev_status = 8'h05; br_mask = 8'h0F; br_match = 8'h05;
        put_desc(32'h200, 4'd6, 2'd0, 2'd1, 2'd0, 16'd0, 32'h0, 32'h240);
        put_desc(32'h210, 4'd0, 2'd0, 2'd0, 2'd0, 16'd4, 32'h400, 32'h0);
        put_desc(32'h240, 4'd6, 2'd0, 2'd2, 2'd0, 16'd0, 32'h0, 32'h210);
        put_desc(32'h250, 4'd7, 2'd0, 2'd0, 2'd0, 16'd0, 32'h0, 32'h0);
        beats0 = beats;
        kick(32'h200);
        wait_idle("R7 branch chain ends");
        check("R7 taken/not-taken no trap beats", beats - beats0, 0);
        check("R5 NOP no wb", mem[32'h20C >> 2], SENT);
        dev_status = 8'h04;
        put_desc(32'h280, 4'd6, 2'd0, 2'd1, 2'd0, 16'd0, 32'h0, 32'h210);
        put_desc(32'h290, 4'd7, 2'd0, 2'd0, 2'd0, 16'd0, 32'h0, 32'h0);
        kick(32'h280);
        wait_idle("R6 false cond ends");
        check("R6 if-true with false cond not taken", beats - beats0, 0);

        // R6 R8: interrupt policy codes against a true condition.
        dev_status = 8'h01; int_mask = 8'h01; int_match = 8'h01;
        put_desc(32'h300, 4'd6, 2'd1, 2'd0, 2'd0, 16'd0, 32'h0, 32'h0);
        put_desc(32'h310, 4'd6, 2'd2, 2'd0, 2'd0, 16'd0, 32'h0, 32'h0);
        put_desc(32'h320, 4'd6, 2'd3, 2'd0, 2'd0, 16'd0, 32'h0, 32'h0);
        put_desc(32'h330, 4'd6, 2'd0, 2'd0, 2'd0, 16'd0, 32'h0, 32'h0);
        put_desc(32'h340, 4'd7, 2'd3, 2'd0, 2'd0, 16'd0, 32'h0, 32'h0);
        irq0 = irq_cnt;
        kick(32'h300);
        wait_idle("R8 nop chain ends");
        check("R6 irq codes 1,3 fire, 0,2 do not", irq_cnt - irq0, 2);

        // R9: wait policy holds before write-back.
        int_mask = 8'h00; int_match = 8'h01;
        dev_status = 8'h81; wt_mask = 8'h80; wt_match = 8'h80;
        put_desc(32'h380, 4'd0, 2'd0, 2'd0, 2'd1, 16'd4, 32'h600, 32'h0);
        put_desc(32'h390, 4'd7, 2'd0, 2'd0, 2'd0, 16'd0, 32'h0, 32'h0);
        push_out(32'h600, 4, 1'b0);
        kick(32'h380);
        repeat (60) @(negedge clk);
        check("R9 held no wb", mem[32'h38C >> 2], SENT);
        check("R9 still active", {31'd0, active}, 1);
        dev_status = 8'h01;
        wait_idle("R9 resumes");
        check("R9 wb after release", mem[32'h38C >> 2], 32'h0401_0000);
        check("R3 wait beat seen", exp_q.size(), 0);

        // R11: load-quad then store-quad.
        dev_status = 8'h00;
        mem[32'h640 >> 2] = 32'hCAFE_F00D;
        put_desc(32'h3C0, 4'd5, 2'd0, 2'd0, 2'd0, 16'd4, 32'h640, 32'h0);
        put_desc(32'h3D0, 4'd4, 2'd0, 2'd0, 2'd0, 16'd4, 32'h644, 32'h0);
        put_desc(32'h3E0, 4'd7, 2'd0, 2'd0, 2'd0, 16'd0, 32'h0, 32'h0);
        kick(32'h3C0);
        wait_idle("R11 quad chain ends");
        check("R11 stored word", mem[32'h644 >> 2], 32'hCAFE_F00D);
        check("R11 quad wb residual 0", mem[32'h3DC >> 2], 32'h0400_0000);

        // R12: zero count, then a count above the limit.
        put_desc(32'h700, 4'd1, 2'd0, 2'd0, 2'd0, 16'd0, 32'h400, 32'h0);
        put_desc(32'h710, 4'd7, 2'd0, 2'd0, 2'd0, 16'd0, 32'h0, 32'h0);
        beats0 = beats;
        kick(32'h700);
        wait_idle("R12 zero ends");
        check("R12 zero count no beats", beats - beats0, 0);
        check("R12 zero count wb", mem[32'h70C >> 2], 32'h0400_0000);
        put_desc(32'h740, 4'd1, 2'd0, 2'd0, 2'd0, 16'hFFFF, 32'h000, 32'h0);
        put_desc(32'h750, 4'd7, 2'd0, 2'd0, 2'd0, 16'd0, 32'h0, 32'h0);
        push_out(32'h000, 32'h8000, 1'b1);
        beats0 = beats;
        kick(32'h740);
        wait_idle("R12 clamp ends");
        check("R12 clamped beat count", beats - beats0, 8192);
        check("R12 scoreboard drained", exp_q.size(), 0);
        check("R12 clamp wb", mem[32'h74C >> 2], 32'h0400_0000);

        summary();
    end
endmodule